// File: doc/BRIEF.md
# Clock-Enable Gate and Power-Down Controller

This block sits in the control path of a synchronous read-only memory and turns the raw clock-enable pin into a per-cycle advance enable for the rest of the core. The pin level registered at one rising edge decides whether the next rising edge moves any internal state. While that enable is low, the core keeps its internal state and its outputs unchanged.

When the pin drops, the block records why the clock stopped. It raises a power-down flag when the device was idle. It raises a suspend flag when a read burst was in progress; a suspended burst is paused, not abandoned. If the pin goes low in the same cycle that a command is presented, that command is blocked and an illegal-command flag is raised. Command decode passes its command strobes through this block and acts only on the returned go strobe.

Top module: `cke_gate`

## Requirements
- R1: `clk_en` equals the value of `cke` sampled at the previous rising edge.
- R2: At an edge where `clk_en` is low, `cmd`, `rd`, `burst_done` and `dev_state` have no effect: no burst starts or ends, and `pdn`, `susp` and `illegal` keep their values.
- R3: If `cke` is sampled low while `clk_en` is high, `dev_state` is idle (2'b00) and no burst is open, `pdn` is high from the next cycle on.
- R4: At the first edge that samples `cke` high again, `pdn` and `susp` clear and `clk_en` returns high. The block is then idle, with `clk_en` high.
- R5: If `cke` is sampled low while `clk_en` is high and a burst is open, `susp` is raised. The burst stays open until `burst_done` is seen at an edge with `clk_en` high, so a later drop before that suspends again.
- R6: A command presented in a cycle where `cke` is low and `clk_en` is high raises `illegal` from the next cycle. `illegal` holds through the frozen cycles and clears at the first enabled edge with no new illegal command.
- R7: `cmd_go` is high only when `cmd` is high, `clk_en` is high and `cke` is high. A read whose `cmd_go` is low opens no burst.
- R8: A `cke` drop while `dev_state` is busy (2'b10) raises neither `pdn` nor `susp`.
- R9: Synchronous reset drives `clk_en` high and clears `pdn`, `susp`, `illegal` and the open-burst state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Raw clock-enable pin level |
| cmd | input | 1 | A decoded command is present |
| rd | input | 1 | The present command is a read (qualified by `cmd`) |
| burst_done | input | 1 | Last beat of the current burst |
| dev_state | input | 2 | Device state code: 00 idle, 01 reading, 10 busy |
| clk_en | output | 1 | Internal advance enable for this cycle |
| cmd_go | output | 1 | The command may execute on this edge |
| pdn | output | 1 | Power-down in effect |
| susp | output | 1 | Clock suspend during a burst |
| illegal | output | 1 | An illegal command was seen on a CKE drop |

## Verification
The assertions assume that `rd` is only raised together with `cmd`. They also assume that `burst_done` only arrives while a burst is open, and that `dev_state` reports reading whenever a burst is open. The vector table keeps to these rules: every read row also sets `cmd`, and `burst_done` is driven only after a read has been accepted. Rows that change inputs while the enable is low test that those inputs are ignored. They are never used to push the state code into combinations the core could not produce.

// File: rtl/cke_gate_pkg.sv
package cke_gate_pkg;
    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        DEV_IDLE = 2'b00,
        DEV_READ = 2'b01,
        DEV_BUSY = 2'b10
    } dev_state_e;

    typedef struct packed {
        logic pdn;
        logic susp;
        logic ill;
    } flags_t;
endpackage

// File: rtl/cke_sampler.sv
module cke_sampler (
    input  logic clk,
    input  logic rst,
    input  logic cke,
    output logic en,
    output logic drop
);
    typedef struct packed {
        logic cke;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d     = smp_q;
        smp_d.cke = rst ? 1'b1 : cke;
    end

    always_ff @(posedge clk) begin
        smp_q <= smp_d;
    end

    assign en   = smp_q.cke;
    assign drop = smp_q.cke & ~cke;

    // R1: the enable follows the pin one edge late
    assert_en_follows_pin_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (en == $past(cke)));
endmodule

// File: rtl/burst_track.sv
module burst_track (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic rd_go,
    input  logic done,
    output logic active
);
    typedef struct packed {
        logic open;
    } bt_t;

    bt_t bt_d, bt_q;

    always_comb begin
        bt_d = bt_q;
        if (rst) begin
            bt_d.open = 1'b0;
        end else if (en) begin
            if (rd_go)
                bt_d.open = 1'b1;
            else if (done)
                bt_d.open = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        bt_q <= bt_d;
    end

    assign active = bt_q.open;

    // R2, R5: a frozen edge neither opens nor closes a burst
    assert_burst_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(active));
endmodule

// File: rtl/mode_flags.sv
module mode_flags
    import cke_gate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cke,
    input  logic en,
    input  logic drop,
    input  logic standby,
    input  logic burst_open,
    input  logic ill_evt,
    output logic pdn,
    output logic susp,
    output logic ill
);
    flags_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (rst) begin
            fl_d = '0;
        end else begin
            if (cke) begin
                fl_d.pdn  = 1'b0;
                fl_d.susp = 1'b0;
            end else if (drop) begin
                fl_d.pdn  = standby;
                fl_d.susp = burst_open;
            end
            if (en)
                fl_d.ill = ill_evt;
        end
    end

    always_ff @(posedge clk) begin
        fl_q <= fl_d;
    end

    assign pdn  = fl_q.pdn;
    assign susp = fl_q.susp;
    assign ill  = fl_q.ill;

    // R3, R5: the two stop reasons exclude each other
    assert_one_reason_R3: assert property (@(posedge clk) disable iff (rst)
        !(pdn && susp));
    // R6: the illegal flag keeps its value over frozen edges
    assert_ill_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(ill));
    // R4: a pin seen high leaves no stop flag behind
    assert_exit_clears_R4: assert property (@(posedge clk) disable iff (rst)
        cke |=> (!pdn && !susp));
endmodule

// File: rtl/cke_gate.sv
module cke_gate
    import cke_gate_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cke,
    input  logic               cmd,
    input  logic               rd,
    input  logic               burst_done,
    input  logic [STATE_W-1:0] dev_state,
    output logic               clk_en,
    output logic               cmd_go,
    output logic               pdn,
    output logic               susp,
    output logic               illegal
);
    logic en, drop, burst_open, standby, rd_go, ill_evt;

    cke_sampler u_smp (
        .clk  (clk),
        .rst  (rst),
        .cke  (cke),
        .en   (en),
        .drop (drop)
    );

    assign cmd_go  = cmd & en & ~drop;
    assign rd_go   = cmd_go & rd;
    assign ill_evt = cmd & drop;
    assign standby = (dev_state == DEV_IDLE) & ~burst_open;

    burst_track u_bt (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .rd_go  (rd_go),
        .done   (burst_done),
        .active (burst_open)
    );

    mode_flags u_fl (
        .clk        (clk),
        .rst        (rst),
        .cke        (cke),
        .en         (en),
        .drop       (drop),
        .standby    (standby),
        .burst_open (burst_open),
        .ill_evt    (ill_evt),
        .pdn        (pdn),
        .susp       (susp),
        .ill        (illegal)
    );

    assign clk_en = en;

    // R7: a command on a falling-pin cycle never executes
    assert_no_go_on_drop_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd && !cke) |-> !cmd_go);
    // R8: a drop while busy names no stop reason
    assert_busy_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (drop && dev_state == DEV_BUSY && !burst_open) |=> (!pdn && !susp));
endmodule

// File: tb/cke_gate_tb.sv
module cke_gate_tb;
    logic       clk = 1'b0;
    logic       rst, cke, cmd, rd, burst_done;
    logic [1:0] dev_state;
    logic       clk_en, cmd_go, pdn, susp, illegal;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cke_gate u_dut (
        .clk(clk), .rst(rst), .cke(cke), .cmd(cmd), .rd(rd),
        .burst_done(burst_done), .dev_state(dev_state),
        .clk_en(clk_en), .cmd_go(cmd_go), .pdn(pdn), .susp(susp), .illegal(illegal)
    );

    // {cke,cmd,rd,done,state[1:0]} _ go (before edge) _ {en,pdn,susp,ill} (after edge)
    localparam int NV = 24;
    localparam logic [10:0] VEC [NV] = '{
        11'b100000_0_1000, // idle, R1
        11'b000000_0_0100, // drop in idle -> power-down, R3
        11'b011000_0_0100, // read while frozen ignored, R2
        11'b100000_0_1000, // exit, R4
        11'b111000_1_1000, // read accepted, R7
        11'b000001_0_0010, // drop in burst -> suspend, R5
        11'b000101_0_0010, // done while frozen ignored, R2
        11'b100001_0_1000, // resume, R4
        11'b000001_0_0010, // burst still open, R5
        11'b100001_0_1000,
        11'b100101_0_1000, // done taken
        11'b000000_0_0100, // now idle, R3
        11'b100000_0_1000,
        11'b010000_0_0101, // command on drop, R6
        11'b000000_0_0101,
        11'b100000_0_1001, // frozen edge holds flag, R6
        11'b100000_0_1000, // clears, R6
        11'b000010_0_0000, // busy drop, R8
        11'b100010_0_1000,
        11'b011000_0_0101, // read on drop rejected, R7
        11'b100000_0_1001,
        11'b100000_0_1000,
        11'b000000_0_0100, // no burst opened, R7
        11'b100000_0_1000
    };

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; cke = 1; cmd = 0; rd = 0; burst_done = 0; dev_state = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        chk(clk_en, 1'b1, "R9 clk_en");
        chk(pdn, 1'b0, "R9 pdn");
        chk(susp, 1'b0, "R9 susp");
        chk(illegal, 1'b0, "R9 illegal");

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {cke, cmd, rd, burst_done, dev_state} = VEC[i][10:5];
            #1;
            chk(cmd_go, VEC[i][4], "R7 cmd_go");
            @(posedge clk); #1;
            chk(clk_en, VEC[i][3], "R1 clk_en");
            chk(pdn, VEC[i][2], "R3 pdn");
            chk(susp, VEC[i][1], "R5 susp");
            chk(illegal, VEC[i][0], "R6 illegal");
        end

        // R9: reset from a power-down overrides the stop state
        @(negedge clk); cke = 0; cmd = 0; rd = 0; burst_done = 0; dev_state = 2'b00;
        @(posedge clk); #1;
        chk(pdn, 1'b1, "R3 pdn before reset");
        @(negedge clk); rst = 1;
        @(posedge clk); #1;
        chk(clk_en, 1'b1, "R9 clk_en in reset");
        chk(pdn, 1'b0, "R9 pdn in reset");
        @(negedge clk); rst = 0;
        @(posedge clk); #1;
        chk(clk_en, 1'b0, "R1 clk_en after reset");
        chk(pdn, 1'b1, "R3 pdn after reset");
        @(negedge clk); cke = 1;
        @(posedge clk); #1;
        chk(pdn, 1'b0, "R4 pdn exit");
        chk(clk_en, 1'b1, "R4 clk_en exit");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule